// File: doc/BRIEF.md
# Rendezvous Channel Handshake Pair

This block joins a receiving controller and a sending controller over one synchronous point-to-point channel. Each controller is started by a one-cycle start pulse and reports completion with a one-cycle finish pulse. The receiver announces that it can accept a word. The sender announces that it has a word and waits until the receiver confirms a match. The two sides may start in any order and any number of cycles apart. The word crosses the channel in the first cycle in which both are ready.

Each side keeps a single pending flop, so it can wait without limit. In the match cycle the receiver raises its synchronisation flag combinationally. The sender drives the word onto the bus only in that cycle, and the bus reads zero at all other times. One cycle after the match, the receive register holds the word and both finish outputs pulse. Two parameters select whether each controller is present. When a controller is left out, the flags it would drive are held at zero.

Top module: `rendezvous_link`

## Requirements
- R1: After reset, with no start pulse applied, inReady, outReady, syncFlag, rxFinish and txFinish are 0, chanData is 0 and rxData is 0.
- R2: inReady is 1 from the cycle in which rxStart is pulsed through the match cycle, inclusive, and is 0 in all other cycles.
- R3: outReady is 1 from the cycle in which txStart is pulsed through the match cycle, inclusive, and is 0 in all other cycles.
- R4: syncFlag is 1 exactly in the cycles where inReady and outReady are both 1. This is the match cycle.
- R5: chanData equals txValue in the match cycle and is all zeros in every other cycle.
- R6: The cycle after a match, rxData holds the word that crossed in the match cycle. Without a match, rxData keeps its value.
- R7: rxFinish and txFinish are each 1 in exactly the cycle after a match and are 0 otherwise.
- R8: A side whose partner never becomes ready keeps its ready flag at 1 on every cycle and never pulses its finish output.
- R9: When the sender is not present (USE_TX = 0), outReady and syncFlag are held at 0. A started receiver then waits with inReady at 1. When the receiver is not present (USE_RX = 0), inReady and syncFlag are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxStart | input | 1 | One-cycle pulse that starts the receiving controller |
| txStart | input | 1 | One-cycle pulse that starts the sending controller |
| txValue | input | W | Word the sender offers; sampled in the match cycle |
| inReady | output | 1 | Receiver is waiting for a word |
| outReady | output | 1 | Sender is waiting to deliver a word |
| syncFlag | output | 1 | Both sides ready in this cycle; the transfer happens now |
| chanData | output | W | Channel bus; carries txValue only in the match cycle, otherwise 0 |
| rxData | output | W | Receive register; loaded at the end of the match cycle |
| rxFinish | output | 1 | Receiver completion pulse, one cycle after the match |
| txFinish | output | 1 | Sender completion pulse, one cycle after the match |

## Verification
A pending flop stuck at 1 shows up at the ports in the cycle after the transfer: the ready flag stays high when it should drop. A pending flop that fails to set drops the ready flag one cycle after its start pulse, before the partner arrives, and the finish pulse never comes. A faulty bus gate or load strobe leaves a nonzero value on chanData outside the match cycle, or a wrong rxData on the edge that produces rxFinish. Each transfer is therefore judged by ready flags checked cycle by cycle while the controllers wait, and by the word and both finish pulses checked one cycle after the match.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

  // Strobes from the handshake control to the channel datapath
  typedef struct packed {
    logic txDrive;  // sender places its word on the channel this cycle
    logic rxLoad;   // receive register captures the channel this cycle
  } rdvStrobes_t;

endpackage

// File: rtl/rdv_ctrl.sv
module rdv_ctrl
  import rdv_pkg::*;
#(
  parameter bit USE_RX = 1'b1,
  parameter bit USE_TX = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxStart,
  input  logic        txStart,
  output logic        inReady,
  output logic        outReady,
  output logic        syncFlag,
  output logic        rxFinish,
  output logic        txFinish,
  output rdvStrobes_t strobes
);

  logic rxActive;
  logic txActive;
  logic txMatch;

  // Receiving side: waits until the sender reports readiness
  generate
    if (USE_RX) begin : g_rx
      logic rxPend;
      always_ff @(posedge clk) begin
        if (!rstN) rxPend <= 1'b0;
        else       rxPend <= rxActive & ~outReady;
      end
      assign rxActive = rxStart | rxPend;
      assign syncFlag = rxActive & outReady;
      always_ff @(posedge clk) begin
        if (!rstN) rxFinish <= 1'b0;
        else       rxFinish <= syncFlag;
      end
    end else begin : g_noRx
      assign rxActive = 1'b0;
      assign syncFlag = 1'b0;
      assign rxFinish = 1'b0;
    end
  endgenerate

  assign inReady = rxActive;

  // Sending side: waits until the receiver reports a match
  generate
    if (USE_TX) begin : g_tx
      logic txPend;
      always_ff @(posedge clk) begin
        if (!rstN) txPend <= 1'b0;
        else       txPend <= txActive & ~syncFlag;
      end
      assign txActive = txStart | txPend;
      always_ff @(posedge clk) begin
        if (!rstN) txFinish <= 1'b0;
        else       txFinish <= txMatch;
      end
    end else begin : g_noTx
      assign txActive = 1'b0;
      assign txFinish = 1'b0;
    end
  endgenerate

  assign outReady = txActive;
  assign txMatch  = txActive & syncFlag;

  assign strobes.txDrive = txMatch;
  assign strobes.rxLoad  = syncFlag;

endmodule

// File: rtl/rdv_datapath.sv
module rdv_datapath
  import rdv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  rdvStrobes_t strobes,
  input  logic [W-1:0] txValue,
  output logic [W-1:0] chanData,
  output logic [W-1:0] rxData
);

  // Each bus bit is gated by the sender's drive strobe
  for (genvar b = 0; b < W; b++) begin : g_gate
    assign chanData[b] = strobes.txDrive & txValue[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rxData <= '0;
    else if (strobes.rxLoad) rxData <= chanData;
  end

endmodule

// File: rtl/rendezvous_link.sv
module rendezvous_link
  import rdv_pkg::*;
#(
  parameter int W      = 8,
  parameter bit USE_RX = 1'b1,
  parameter bit USE_TX = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxStart,
  input  logic         txStart,
  input  logic [W-1:0] txValue,
  output logic         inReady,
  output logic         outReady,
  output logic         syncFlag,
  output logic [W-1:0] chanData,
  output logic [W-1:0] rxData,
  output logic         rxFinish,
  output logic         txFinish
);

  rdvStrobes_t strobes;

  rdv_ctrl #(.USE_RX(USE_RX), .USE_TX(USE_TX)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxStart (rxStart),
    .txStart (txStart),
    .inReady (inReady),
    .outReady(outReady),
    .syncFlag(syncFlag),
    .rxFinish(rxFinish),
    .txFinish(txFinish),
    .strobes (strobes)
  );

  rdv_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txValue (txValue),
    .chanData(chanData),
    .rxData  (rxData)
  );

endmodule

// File: rtl/rdv_checker.sv
module rdv_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inReady,
  input logic         outReady,
  input logic         syncFlag,
  input logic [W-1:0] chanData,
  input logic [W-1:0] rxData,
  input logic         rxFinish,
  input logic         txFinish
);

  AST_SYNC_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |-> (inReady && outReady)); // R4

  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !syncFlag |-> (chanData == '0)); // R5

  AST_RX_LOADS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |=> (rxData == $past(chanData))); // R6

  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !syncFlag |=> $stable(rxData)); // R6

  AST_FINISH_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag |=> (rxFinish && txFinish)); // R7

  AST_RX_FINISH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rxFinish |-> $past(syncFlag)); // R7

  AST_TX_FINISH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txFinish |-> $past(syncFlag)); // R7

  AST_RX_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !outReady) |=> inReady); // R8

  AST_TX_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && !syncFlag) |=> outReady); // R8

endmodule

bind rendezvous_link rdv_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inReady (inReady),
  .outReady(outReady),
  .syncFlag(syncFlag),
  .chanData(chanData),
  .rxData  (rxData),
  .rxFinish(rxFinish),
  .txFinish(txFinish)
);

// File: tb/tb_rendezvous_link.sv
`timescale 1ns/100ps
module tb_rendezvous_link;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxStart = 1'b0, txStart = 1'b0;
  logic [W-1:0] txValue = '0;
  logic inReady, outReady, syncFlag, rxFinish, txFinish;
  logic [W-1:0] chanData, rxData;

  // Receiver-only instance
  logic rxStartB = 1'b0;
  logic inReadyB, outReadyB, syncFlagB, rxFinishB, txFinishB;
  logic [W-1:0] chanDataB, rxDataB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] expQ[$];

  always #2.5 clk = ~clk;

  rendezvous_link #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .txStart(txStart),
    .txValue(txValue), .inReady(inReady), .outReady(outReady),
    .syncFlag(syncFlag), .chanData(chanData), .rxData(rxData),
    .rxFinish(rxFinish), .txFinish(txFinish)
  );

  rendezvous_link #(.W(W), .USE_RX(1'b1), .USE_TX(1'b0)) dutRxOnly (
    .clk(clk), .rstN(rstN), .rxStart(rxStartB), .txStart(1'b0),
    .txValue('0), .inReady(inReadyB), .outReady(outReadyB),
    .syncFlag(syncFlagB), .chanData(chanDataB), .rxData(rxDataB),
    .rxFinish(rxFinishB), .txFinish(txFinishB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the expected word when the receiver finishes
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rxFinish) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected rxFinish", 1, 0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(rxData == e, "R6 rxData", int'(rxData), int'(e));
          check(txFinish == 1'b1, "R7 txFinish with rxFinish", int'(txFinish), 1);
        end
      end else if (txFinish) begin
        check(1'b0, "R7 txFinish without rxFinish", 1, 0);
      end
    end
  end

  // Driver: start both sides with given delays, check flags each cycle
  task automatic runXfer(input int rxD, input int txD, input logic [W-1:0] val);
    int m;
    m = (rxD > txD) ? rxD : txD;
    expQ.push_back(val);
    for (int c = 0; c <= m; c++) begin
      @(negedge clk);
      txValue = val;
      rxStart = (c == rxD);
      txStart = (c == txD);
      #1;
      check(inReady == (c >= rxD), "R2 inReady", int'(inReady), int'(c >= rxD));
      check(outReady == (c >= txD), "R3 outReady", int'(outReady), int'(c >= txD));
      check(syncFlag == (c == m), "R4 syncFlag", int'(syncFlag), int'(c == m));
      check(chanData == ((c == m) ? val : '0), "R5 chanData",
            int'(chanData), int'((c == m) ? val : '0));
      if (c < m) check(!rxFinish && !txFinish, "R8 no finish while waiting",
                       int'({rxFinish, txFinish}), 0);
    end
    @(negedge clk);
    rxStart = 1'b0;
    txStart = 1'b0;
    #1;
    check(!inReady && !outReady && !syncFlag, "R2 R3 flags drop after match",
          int'({inReady, outReady, syncFlag}), 0);
    @(negedge clk);
    txValue = ~val;
    #1;
    check(rxData == val, "R6 rxData holds", int'(rxData), int'(val));
    check(chanData == '0, "R5 idle bus", int'(chanData), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!inReady && !outReady && !syncFlag && !rxFinish && !txFinish,
          "R1 flags at reset", int'({inReady, outReady, syncFlag, rxFinish, txFinish}), 0);
    check(rxData == '0 && chanData == '0, "R1 data at reset", int'(rxData), 0);

    runXfer(0, 0, 8'hA5);
    runXfer(3, 0, 8'h3C);
    runXfer(0, 4, 8'hFF);
    runXfer(2, 2, 8'h00);
    runXfer(5, 1, 8'h81);
    runXfer(30, 0, 8'h5A);  // long sender wait, R8
    runXfer(0, 30, 8'hC3);  // long receiver wait, R8

    // Receiver with absent sender waits forever
    @(negedge clk);
    rxStartB = 1'b1;
    for (int c = 0; c < 20; c++) begin
      #1;
      check(inReadyB == 1'b1, "R8 R9 receiver keeps waiting", int'(inReadyB), 1);
      check(!outReadyB && !syncFlagB, "R9 absent sender flags zero",
            int'({outReadyB, syncFlagB}), 0);
      check(!rxFinishB && !txFinishB, "R8 no finish without partner",
            int'({rxFinishB, txFinishB}), 0);
      @(negedge clk);
      rxStartB = 1'b0;
    end

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R7 every transfer finished", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule